// File: doc/BRIEF.md
# Accumulator Status Flag Unit

This block derives and holds four status flags for a 36-bit accumulator datapath. The accumulator carries 32 data bits under 4 guard bits. For each operation the block receives the 36-bit result, the sign bits of the two operands and the kind of operation: add, subtract, logical or bit-manipulation. A strobe says whether the operation sets the flags. A plain accumulator load, such as a data move or a multiply/transfer write, holds the strobe low and leaves the flags unchanged.

The latched flags are minus, equal, a full-width 36-bit overflow and a 32-bit overflow. The 32-bit overflow is set when the data sign bit (bit 31) disagrees with any guard bit. A 4-bit condition selector picks a test, and the block evaluates that test against the latched flags to give one condition-true bit for conditional execution. The test reads the register, so an operation that sets the flags in one cycle affects condition tests from the next cycle onward.

Top module: `acc_status_flags`

## Requirements
- R1: After a flag-setting operation, `flag_minus` equals bit 35 of that operation's result.
- R2: After a flag-setting operation, `flag_equal` is 1 exactly when all 36 result bits are zero.
- R3: `flag_ovf36` is set for add (op 0) when both operand signs match and the result sign differs from operand A's sign. It is set for subtract (op 1) when the operand signs differ and the result sign differs from operand A's sign. Logical (op 2) and bit-manipulation (op 3) operations clear it.
- R4: `flag_ovf32` is 1 when result bit 31 differs from at least one of result bits 32, 33, 34 and 35.
- R5: Flags load on a rising clock edge at which `flag_set` is high, and the new values appear on the outputs after that edge.
- R6: While `flag_set` is low, all four flags keep their values whatever the result, operand and op inputs carry.
- R7: A synchronous active-high reset clears all four flags to 0 and takes priority over `flag_set`.
- R8: `cond_true` is a combinational function of the latched flags and `cond_sel`. The codes are: 0 always; 1 minus; 2 not minus; 3 equal; 4 not equal; 5 greater than (neither minus nor equal); 6 less or equal (minus or equal); 7 ovf36; 8 not ovf36; 9 ovf32; 10 not ovf32. A test made in the same cycle as a flag-setting operation sees the flags from before that operation.
- R9: Condition codes 11 to 15 always give `cond_true` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| flag_set | input | 1 | High for a flag-setting operation, low for a plain load |
| op | input | 2 | Operation kind: 0 add, 1 subtract, 2 logical, 3 bit-manipulation |
| opa_sign | input | 1 | Sign bit (bit 35) of operand A |
| opb_sign | input | 1 | Sign bit (bit 35) of operand B |
| result | input | 36 | Operation result |
| cond_sel | input | 4 | Condition code selector |
| flag_minus | output | 1 | Latched minus flag |
| flag_equal | output | 1 | Latched equal (zero) flag |
| flag_ovf36 | output | 1 | Latched 36-bit overflow flag |
| flag_ovf32 | output | 1 | Latched 32-bit overflow flag |
| cond_true | output | 1 | Result of the selected test on the latched flags |

## Verification
The assertions are evaluated on every cycle. They cover four things: the flags hold while the strobe is low, reset clears them, logical and bit-manipulation operations leave the wide overflow clear, and the latched minus and equal flags match the result that set them. Some checks need chosen stimulus and appear only in the bench scenarios. These are the arithmetic corner cases: 0x7FFFFFFFF + 1, a result of 0x080000000, and the 36-bit wrap to zero. They also include every condition code against known flag patterns, reset winning over the strobe, and a condition test made in the same cycle as the flag update.

// File: rtl/acc_flag_pkg.sv
package acc_flag_pkg;

    localparam int DATA_W  = 32;
    localparam int GUARD_W = 4;
    localparam int ACC_W   = DATA_W + GUARD_W;
    localparam int CC_W    = 4;

    typedef enum logic [1:0] {
        OP_ADD    = 2'd0,
        OP_SUB    = 2'd1,
        OP_LOGIC  = 2'd2,
        OP_BITMAN = 2'd3
    } op_kind_e;

    typedef enum logic [CC_W-1:0] {
        CC_ALWAYS = 4'd0,
        CC_MI     = 4'd1,
        CC_PL     = 4'd2,
        CC_EQ     = 4'd3,
        CC_NE     = 4'd4,
        CC_GT     = 4'd5,
        CC_LE     = 4'd6,
        CC_OV36   = 4'd7,
        CC_NOV36  = 4'd8,
        CC_OV32   = 4'd9,
        CC_NOV32  = 4'd10
    } cc_e;

    typedef struct packed {
        logic minus;
        logic zero;
        logic ovf_wide;
        logic ovf_narrow;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{minus: 1'b0, zero: 1'b0, ovf_wide: 1'b0, ovf_narrow: 1'b0};

    // Signed overflow from operand and result sign bits.
    function automatic logic sign_overflow(op_kind_e k, logic sa, logic sb, logic sr);
        logic ovf;
        case (k)
            OP_ADD:  ovf = (sa == sb) && (sr != sa);
            OP_SUB:  ovf = (sa != sb) && (sr != sa);
            default: ovf = 1'b0;
        endcase
        return ovf;
    endfunction

endpackage

// File: rtl/acc_flag_calc.sv
module acc_flag_calc
    import acc_flag_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int GW = GUARD_W,
    localparam int AW = DW + GW
) (
    input  op_kind_e        op,
    input  logic            a_sign,
    input  logic            b_sign,
    input  logic [AW-1:0]   res,
    output flags_t          nxt
);

    logic [GW-1:0] guard_diff;

    // One comparator per guard bit against the data sign bit.
    for (genvar g = 0; g < GW; g++) begin : g_guard
        assign guard_diff[g] = res[DW+g] ^ res[DW-1];
    end

    always_comb begin
        nxt            = FLAGS_CLEAR;
        nxt.minus      = res[AW-1];
        nxt.zero       = ~|res;
        nxt.ovf_wide   = sign_overflow(op, a_sign, b_sign, res[AW-1]);
        nxt.ovf_narrow = |guard_diff;
    end

    // A zero result has matching guard and sign bits (R4, R2)
    always_comb begin
        assert_zero_no_ovf32_R4: assert (!(nxt.zero && nxt.ovf_narrow));
    end

endmodule

// File: rtl/acc_flag_reg.sv
module acc_flag_reg
    import acc_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= FLAGS_CLEAR;
        else if (load) q <= d;
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    assert_reset_R7: assert property (@(posedge clk)
        rst |=> (q == FLAGS_CLEAR));

endmodule

// File: rtl/acc_cond_eval.sv
module acc_cond_eval
    import acc_flag_pkg::*;
(
    input  flags_t          fl,
    input  logic [CC_W-1:0] sel,
    output logic            hit
);

    always_comb begin
        case (cc_e'(sel))
            CC_ALWAYS: hit = 1'b1;
            CC_MI:     hit = fl.minus;
            CC_PL:     hit = ~fl.minus;
            CC_EQ:     hit = fl.zero;
            CC_NE:     hit = ~fl.zero;
            CC_GT:     hit = ~fl.minus & ~fl.zero;
            CC_LE:     hit = fl.minus | fl.zero;
            CC_OV36:   hit = fl.ovf_wide;
            CC_NOV36:  hit = ~fl.ovf_wide;
            CC_OV32:   hit = fl.ovf_narrow;
            CC_NOV32:  hit = ~fl.ovf_narrow;
            default:   hit = 1'b0;
        endcase
    end

    // Unused codes never pass (R9)
    always_comb begin
        if (sel > 4'd10) assert_unused_false_R9: assert (!hit);
    end

endmodule

// File: rtl/acc_status_flags.sv
module acc_status_flags
    import acc_flag_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int GW = GUARD_W,
    localparam int AW = DW + GW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flag_set,
    input  logic [1:0]      op,
    input  logic            opa_sign,
    input  logic            opb_sign,
    input  logic [AW-1:0]   result,
    input  logic [CC_W-1:0] cond_sel,
    output logic            flag_minus,
    output logic            flag_equal,
    output logic            flag_ovf36,
    output logic            flag_ovf32,
    output logic            cond_true
);

    flags_t next_flags;
    flags_t cur_flags;

    acc_flag_calc #(.DW(DW), .GW(GW)) u_calc (
        .op     (op_kind_e'(op)),
        .a_sign (opa_sign),
        .b_sign (opb_sign),
        .res    (result),
        .nxt    (next_flags)
    );

    acc_flag_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (flag_set),
        .d    (next_flags),
        .q    (cur_flags)
    );

    acc_cond_eval u_cond (
        .fl  (cur_flags),
        .sel (cond_sel),
        .hit (cond_true)
    );

    assign flag_minus = cur_flags.minus;
    assign flag_equal = cur_flags.zero;
    assign flag_ovf36 = cur_flags.ovf_wide;
    assign flag_ovf32 = cur_flags.ovf_narrow;

    assert_minus_R1: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> (flag_minus == $past(result[AW-1])));

    assert_equal_R2: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> (flag_equal == ($past(result) == '0)));

    assert_logic_no_ovf_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_set && op[1]) |=> !flag_ovf36);

    assert_update_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_set && result == '0) |=> (flag_equal && !flag_minus && !flag_ovf32));

endmodule

// File: tb/acc_status_flags_bench.sv
module acc_status_flags_bench;

    localparam int AW = 36;
    localparam int VW = 2 + 3 * AW + 4;
    localparam int NV = 10;

    // {op, a, b, result, expected {minus, equal, ovf36, ovf32}}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 36'h7FFFFFFFF, 36'h000000001, 36'h800000000, 4'b1011},
        {2'd0, 36'h07FFFFFFF, 36'h000000001, 36'h080000000, 4'b0001},
        {2'd1, 36'h000000005, 36'h000000005, 36'h000000000, 4'b0100},
        {2'd0, 36'hFFFFFFFFF, 36'h000000001, 36'h000000000, 4'b0100},
        {2'd1, 36'h800000000, 36'h000000001, 36'h7FFFFFFFF, 4'b0011},
        {2'd2, 36'h7FFFFFFFF, 36'h800000000, 36'hFFFFFFFFF, 4'b1000},
        {2'd0, 36'h000000001, 36'h000000002, 36'h000000003, 4'b0000},
        {2'd1, 36'h000000000, 36'h000000001, 36'hFFFFFFFFF, 4'b1000},
        {2'd3, 36'h800000000, 36'h800000000, 36'h000000000, 4'b0100},
        {2'd0, 36'h800000000, 36'h800000000, 36'h000000000, 4'b0110}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          flag_set;
    logic [1:0]    op;
    logic          opa_sign, opb_sign;
    logic [AW-1:0] result;
    logic [3:0]    cond_sel;
    logic          flag_minus, flag_equal, flag_ovf36, flag_ovf32, cond_true;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    acc_status_flags u_acc_status_flags (
        .clk(clk), .rst(rst), .flag_set(flag_set), .op(op),
        .opa_sign(opa_sign), .opb_sign(opb_sign), .result(result),
        .cond_sel(cond_sel), .flag_minus(flag_minus), .flag_equal(flag_equal),
        .flag_ovf36(flag_ovf36), .flag_ovf32(flag_ovf32), .cond_true(cond_true)
    );

    function automatic logic [3:0] got();
        return {flag_minus, flag_equal, flag_ovf36, flag_ovf32};
    endfunction

    // Reference flags written from the requirements with wide arithmetic.
    function automatic logic [3:0] model(logic [1:0] k, logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] r);
        logic signed [AW+1:0] wa, wb, wr;
        logic ov;
        wa = {{2{a[AW-1]}}, a};
        wb = {{2{b[AW-1]}}, b};
        wr = (k == 2'd0) ? wa + wb : wa - wb;
        ov = (k[1] == 1'b0) && ((wr > 38'sh07FFFFFFFF) || (wr < -38'sh0800000000));
        return {r[AW-1], r == '0, ov, !(r[35:31] == 5'h00 || r[35:31] == 5'h1F)};
    endfunction

    function automatic logic model_cond(logic [3:0] f, logic [3:0] c);
        logic mi, eq, v36, v32;
        {mi, eq, v36, v32} = f;
        if (c == 0) return 1'b1;
        if (c == 1 || c == 2) return mi ^ (c == 2);
        if (c == 3 || c == 4) return eq ^ (c == 4);
        if (c == 5) return !(mi || eq);
        if (c == 6) return mi || eq;
        if (c == 7 || c == 8) return v36 ^ (c == 8);
        if (c == 9 || c == 10) return v32 ^ (c == 10);
        return 1'b0;
    endfunction

    task automatic check(logic ok, string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(logic s, logic [1:0] k, logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] r);
        @(negedge clk);
        flag_set = s; op = k; opa_sign = a[AW-1]; opb_sign = b[AW-1]; result = r;
        @(posedge clk);
        #1;
        flag_set = 1'b0;
    endtask

    task automatic sweep_conds(logic [3:0] f);
        for (int c = 0; c < 16; c++) begin
            cond_sel = 4'(c);
            #1;
            if (c > 10) check(cond_true == 1'b0, "R9 unused code", 36'(cond_true), 36'd0);
            else        check(cond_true == model_cond(f, 4'(c)), "R8 cond code", 36'(cond_true), 36'(model_cond(f, 4'(c))));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] exp_f, held;
        rst = 1'b1; flag_set = 1'b0; op = 2'd0; opa_sign = 1'b0; opb_sign = 1'b0;
        result = '0; cond_sel = 4'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(got() == 4'b0000, "R7 reset state", 36'(got()), 36'd0);
        rst = 1'b0;

        // Table walk: R1 R2 R3 R4 R5 and condition codes R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [1:0] k; logic [AW-1:0] a, b, r; logic [3:0] e;
            {k, a, b, r, e} = VEC[i];
            apply(1'b1, k, a, b, r);
            check(got() == e, "R1 R2 R3 R4 table vector", 36'(got()), 36'(e));
            check(model(k, a, b, r) == e, "R3 table vs model", 36'(model(k, a, b, r)), 36'(e));
            sweep_conds(e);
        end

        // Plain loads leave flags untouched (R6)
        apply(1'b1, 2'd0, 36'h7FFFFFFFF, 36'h1, 36'h800000000);
        held = got();
        apply(1'b0, 2'd2, 36'h0, 36'h0, 36'h000000000);
        check(got() == held, "R6 load with zero result", 36'(got()), 36'(held));
        apply(1'b0, 2'd1, 36'h0, 36'h800000000, 36'h080000000);
        check(got() == held, "R6 load with ovf32 pattern", 36'(got()), 36'(held));

        // Same-cycle test sees old flags (R8)
        @(negedge clk);
        cond_sel = 4'd3; flag_set = 1'b1; op = 2'd2; result = '0; opa_sign = 0; opb_sign = 0;
        #1;
        check(cond_true == 1'b0, "R8 same-cycle old flags", 36'(cond_true), 36'd0);
        @(posedge clk);
        #1;
        flag_set = 1'b0;
        check(cond_true == 1'b1, "R5 R8 next-cycle new flags", 36'(cond_true), 36'd1);

        // Reset wins over flag_set (R7)
        apply(1'b1, 2'd0, 36'h7FFFFFFFF, 36'h1, 36'h800000000);
        @(negedge clk);
        rst = 1'b1; flag_set = 1'b1; op = 2'd2; result = 36'hFFFFFFFFF;
        @(posedge clk);
        #1;
        check(got() == 4'b0000, "R7 reset priority", 36'(got()), 36'd0);
        rst = 1'b0; flag_set = 1'b0;

        // Random operations with random strobe (R1..R6)
        exp_f = got();
        for (int n = 0; n < 400; n++) begin
            logic [1:0] k; logic [AW-1:0] a, b, r; logic s;
            k = 2'($urandom_range(0, 3));
            a = {4'($urandom), 32'($urandom)};
            b = (n % 5 == 0) ? a : {4'($urandom), 32'($urandom)};
            s = ($urandom_range(0, 3) != 0);
            case (k)
                2'd0:    r = a + b;
                2'd1:    r = a - b;
                2'd2:    r = a & b;
                default: r = a ^ b;
            endcase
            apply(s, k, a, b, r);
            if (s) exp_f = model(k, a, b, r);
            check(got() == exp_f, s ? "R1 R2 R3 R4 R5 random op" : "R6 random hold",
                  36'(got()), 36'(exp_f));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule